// File: doc/BRIEF.md
# Warp-Indexed Register Scoreboard

This block records, separately for every warp, which architectural registers still have a write on its way through the pipeline. The issue stage presents a candidate instruction on the query port. The query gives a warp number, a destination register and up to two source registers, each with its own valid bit. The block answers in the same cycle whether that instruction may issue without a read-after-write or write-after-write conflict.

When an instruction issues, the issue stage pulses the reserve port with the warp and destination register. When the result is written back, the writeback stage pulses the release port with the same pair. A warp may have several instructions in flight at once, provided their registers do not collide. Reservations in one warp never block another warp. A release that names a register with nothing pending leaves the state alone and produces a one-cycle error pulse.

Top module: `warp_scoreboard`

## Requirements
- R1: After reset no register of any warp is pending: every query reports hazard-free (`clear_o`=1, `raw_o`=0, `waw_o`=0), and `rel_err_o` is 0.
- R2: A reserve pulse marks (warp, register) pending from the next clock edge onward. Pending state changes only on reserve or release pulses.
- R3: A source operand with its valid bit set, whose register is pending in the queried warp, raises `raw_o` and drops `clear_o`.
- R4: A destination with its valid bit set, whose register is pending in the queried warp, raises `waw_o` and drops `clear_o`.
- R5: Pending state is kept per warp. A register reserved in one warp does not block the same register number in any other warp.
- R6: A release pulse clears the pending mark of (warp, register) from the next clock edge onward.
- R7: When a reserve and a release name the same (warp, register) in the same cycle, the register ends up pending.
- R8: The query reads the state held before the current edge. A reservation made in the same cycle as a query is not seen by that query.
- R9: A release of a register that is not pending changes no state. It drives `rel_err_o` high for exactly the one cycle that follows the release edge. In every other cycle `rel_err_o` is 0.
- R10: An operand whose valid bit is 0 never causes a hazard, whatever register number it carries.
- R11: Several distinct registers of one warp can be pending together. Releasing one of them leaves the others pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chk_warp_i | input | 3 | Warp of the queried instruction |
| chk_dst_i | input | 6 | Destination register of the query |
| chk_dst_vld_i | input | 1 | Destination field is in use |
| chk_src0_i | input | 6 | First source register |
| chk_src0_vld_i | input | 1 | First source field is in use |
| chk_src1_i | input | 6 | Second source register |
| chk_src1_vld_i | input | 1 | Second source field is in use |
| rsv_en_i | input | 1 | Reserve pulse (instruction issued) |
| rsv_warp_i | input | 3 | Warp to reserve in |
| rsv_reg_i | input | 6 | Register to reserve |
| rel_en_i | input | 1 | Release pulse (result written back) |
| rel_warp_i | input | 3 | Warp to release in |
| rel_reg_i | input | 6 | Register to release |
| clear_o | output | 1 | Query is free of hazards |
| raw_o | output | 1 | A valid source is pending |
| waw_o | output | 1 | The valid destination is pending |
| rel_err_o | output | 1 | Registered pulse: the previous release hit a register with nothing pending |

## Verification
The bench goes after a reserve and a query on the same register in one cycle. A design that forwarded the reservation would block an instruction it should pass. It also drives a reserve and a release on the same register together. A design with the wrong priority would drop a live reservation, so a later reader would be let through too early. It releases registers that were never reserved and checks that neighbouring pending bits survive. A design that toggled instead of clearing would create phantom hazards, and a combinational or sticky error flag would show at the wrong cycle. Cross-warp queries and queries whose valid bits are low catch a design that ignores the warp index or the valid bits.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
  localparam int unsigned WSB_WARPS = 8;
  localparam int unsigned WSB_REGS  = 64;

  // Linear position of a (warp, register) pair in the flattened pending vector.
  function automatic int unsigned slot_of(int unsigned warp, int unsigned rid,
                                          int unsigned nregs);
    return warp * nregs + rid;
  endfunction

  // A field only conflicts when it is in use and its register is pending.
  function automatic logic field_hit(logic used, logic pending);
    return used & pending;
  endfunction
endpackage

// File: rtl/wsb_pend_bank.sv
module wsb_pend_bank
  import wsb_pkg::*;
#(
  parameter int unsigned NUM_WARPS = WSB_WARPS,
  parameter int unsigned NUM_REGS  = WSB_REGS,
  localparam int unsigned WID_W = $clog2(NUM_WARPS),
  localparam int unsigned RID_W = $clog2(NUM_REGS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          set_en_i,
  input  logic [WID_W-1:0]              set_warp_i,
  input  logic [RID_W-1:0]              set_reg_i,
  input  logic                          clr_en_i,
  input  logic [WID_W-1:0]              clr_warp_i,
  input  logic [RID_W-1:0]              clr_reg_i,
  output logic [NUM_WARPS*NUM_REGS-1:0] pend_o
);
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic [NUM_REGS-1:0] row_q;
    logic [NUM_REGS-1:0] set_mask;
    logic [NUM_REGS-1:0] clr_mask;
    logic                set_here;
    logic                clr_here;

    assign set_here = set_en_i && (set_warp_i == WID_W'(w));
    assign clr_here = clr_en_i && (clr_warp_i == WID_W'(w));
    assign set_mask = set_here ? (NUM_REGS'(1) << set_reg_i) : '0;
    assign clr_mask = clr_here ? (NUM_REGS'(1) << clr_reg_i) : '0;

    // Clear first, then set: a reserve overrides a release of the same bit.
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        row_q <= '0;
      end else if (set_here || clr_here) begin
        row_q <= (row_q & ~clr_mask) | set_mask;
      end
    end

    assign pend_o[w*NUM_REGS +: NUM_REGS] = row_q;
  end
endmodule

// File: rtl/wsb_hazard_query.sv
module wsb_hazard_query
  import wsb_pkg::*;
#(
  parameter int unsigned NUM_WARPS = WSB_WARPS,
  parameter int unsigned NUM_REGS  = WSB_REGS,
  localparam int unsigned WID_W = $clog2(NUM_WARPS),
  localparam int unsigned RID_W = $clog2(NUM_REGS)
) (
  input  logic [NUM_WARPS*NUM_REGS-1:0] pend_i,
  input  logic [WID_W-1:0]              warp_i,
  input  logic [RID_W-1:0]              dst_i,
  input  logic                          dst_vld_i,
  input  logic [RID_W-1:0]              src0_i,
  input  logic                          src0_vld_i,
  input  logic [RID_W-1:0]              src1_i,
  input  logic                          src1_vld_i,
  output logic                          raw_o,
  output logic                          waw_o,
  output logic                          clear_o
);
  logic [NUM_REGS-1:0] row;

  assign row     = pend_i[slot_of(warp_i, 0, NUM_REGS) +: NUM_REGS];
  assign raw_o   = field_hit(src0_vld_i, row[src0_i]) | field_hit(src1_vld_i, row[src1_i]);
  assign waw_o   = field_hit(dst_vld_i, row[dst_i]);
  assign clear_o = ~(raw_o | waw_o);
endmodule

// File: rtl/wsb_release_mon.sv
module wsb_release_mon
  import wsb_pkg::*;
#(
  parameter int unsigned NUM_WARPS = WSB_WARPS,
  parameter int unsigned NUM_REGS  = WSB_REGS,
  localparam int unsigned WID_W = $clog2(NUM_WARPS),
  localparam int unsigned RID_W = $clog2(NUM_REGS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_WARPS*NUM_REGS-1:0] pend_i,
  input  logic                          rel_en_i,
  input  logic [WID_W-1:0]              rel_warp_i,
  input  logic [RID_W-1:0]              rel_reg_i,
  output logic                          miss_o,
  output logic                          err_o
);
  logic err_q;

  assign miss_o = rel_en_i & ~pend_i[slot_of(rel_warp_i, rel_reg_i, NUM_REGS)];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= miss_o;
  end

  assign err_o = err_q;
endmodule

// File: rtl/warp_scoreboard.sv
module warp_scoreboard
  import wsb_pkg::*;
#(
  parameter int unsigned NUM_WARPS = WSB_WARPS,
  parameter int unsigned NUM_REGS  = WSB_REGS,
  localparam int unsigned WID_W = $clog2(NUM_WARPS),
  localparam int unsigned RID_W = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WID_W-1:0] chk_warp_i,
  input  logic [RID_W-1:0] chk_dst_i,
  input  logic             chk_dst_vld_i,
  input  logic [RID_W-1:0] chk_src0_i,
  input  logic             chk_src0_vld_i,
  input  logic [RID_W-1:0] chk_src1_i,
  input  logic             chk_src1_vld_i,
  input  logic             rsv_en_i,
  input  logic [WID_W-1:0] rsv_warp_i,
  input  logic [RID_W-1:0] rsv_reg_i,
  input  logic             rel_en_i,
  input  logic [WID_W-1:0] rel_warp_i,
  input  logic [RID_W-1:0] rel_reg_i,
  output logic             clear_o,
  output logic             raw_o,
  output logic             waw_o,
  output logic             rel_err_o
);
  logic [NUM_WARPS*NUM_REGS-1:0] pend_flat;
  logic                          rel_miss;

  wsb_pend_bank #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_en_i   (rsv_en_i),
    .set_warp_i (rsv_warp_i),
    .set_reg_i  (rsv_reg_i),
    .clr_en_i   (rel_en_i),
    .clr_warp_i (rel_warp_i),
    .clr_reg_i  (rel_reg_i),
    .pend_o     (pend_flat)
  );

  wsb_hazard_query #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS)) u_query (
    .pend_i     (pend_flat),
    .warp_i     (chk_warp_i),
    .dst_i      (chk_dst_i),
    .dst_vld_i  (chk_dst_vld_i),
    .src0_i     (chk_src0_i),
    .src0_vld_i (chk_src0_vld_i),
    .src1_i     (chk_src1_i),
    .src1_vld_i (chk_src1_vld_i),
    .raw_o      (raw_o),
    .waw_o      (waw_o),
    .clear_o    (clear_o)
  );

  wsb_release_mon #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS)) u_relmon (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_i     (pend_flat),
    .rel_en_i   (rel_en_i),
    .rel_warp_i (rel_warp_i),
    .rel_reg_i  (rel_reg_i),
    .miss_o     (rel_miss),
    .err_o      (rel_err_o)
  );
endmodule

// File: rtl/wsb_checker.sv
module wsb_checker
  import wsb_pkg::*;
#(
  parameter int unsigned NUM_WARPS = WSB_WARPS,
  parameter int unsigned NUM_REGS  = WSB_REGS,
  localparam int unsigned WID_W = $clog2(NUM_WARPS),
  localparam int unsigned RID_W = $clog2(NUM_REGS),
  localparam int unsigned IDX_W = $clog2(NUM_WARPS*NUM_REGS)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_WARPS*NUM_REGS-1:0] pend_flat,
  input logic [WID_W-1:0]              chk_warp_i,
  input logic [RID_W-1:0]              chk_dst_i,
  input logic                          chk_dst_vld_i,
  input logic [RID_W-1:0]              chk_src0_i,
  input logic                          chk_src0_vld_i,
  input logic [RID_W-1:0]              chk_src1_i,
  input logic                          chk_src1_vld_i,
  input logic                          rsv_en_i,
  input logic [WID_W-1:0]              rsv_warp_i,
  input logic [RID_W-1:0]              rsv_reg_i,
  input logic                          rel_en_i,
  input logic [WID_W-1:0]              rel_warp_i,
  input logic [RID_W-1:0]              rel_reg_i,
  input logic                          clear_o,
  input logic                          raw_o,
  input logic                          waw_o,
  input logic                          rel_err_o
);
  logic [IDX_W-1:0] rsv_idx, rel_idx, rsv_idx_q, rel_idx_q;
  logic [IDX_W-1:0] src0_idx, src1_idx, dst_idx;

  assign rsv_idx  = IDX_W'(slot_of(rsv_warp_i, rsv_reg_i, NUM_REGS));
  assign rel_idx  = IDX_W'(slot_of(rel_warp_i, rel_reg_i, NUM_REGS));
  assign src0_idx = IDX_W'(slot_of(chk_warp_i, chk_src0_i, NUM_REGS));
  assign src1_idx = IDX_W'(slot_of(chk_warp_i, chk_src1_i, NUM_REGS));
  assign dst_idx  = IDX_W'(slot_of(chk_warp_i, chk_dst_i, NUM_REGS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsv_idx_q <= '0;
      rel_idx_q <= '0;
    end else begin
      rsv_idx_q <= rsv_idx;
      rel_idx_q <= rel_idx;
    end
  end

  p_reserve_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsv_en_i |=> pend_flat[rsv_idx_q]);

  p_quiet_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rsv_en_i && !rel_en_i) |=> $stable(pend_flat));

  p_src0_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_src0_vld_i && pend_flat[src0_idx]) |-> (raw_o && !clear_o));

  p_src1_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_src1_vld_i && pend_flat[src1_idx]) |-> (raw_o && !clear_o));

  p_dst_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_dst_vld_i && pend_flat[dst_idx]) |-> (waw_o && !clear_o));

  p_release_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_en_i && !(rsv_en_i && rsv_idx == rel_idx)) |=> !pend_flat[rel_idx_q]);

  p_reserve_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsv_en_i && rel_en_i && rsv_idx == rel_idx) |=> pend_flat[rsv_idx_q]);

  p_err_on_miss_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_en_i && !pend_flat[rel_idx]) |=> rel_err_o);

  p_err_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rel_en_i || pend_flat[rel_idx]) |=> !rel_err_o);

  p_unused_free_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chk_dst_vld_i && !chk_src0_vld_i && !chk_src1_vld_i) |-> (clear_o && !raw_o && !waw_o));
endmodule

bind warp_scoreboard wsb_checker #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS)) u_wsb_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .pend_flat      (pend_flat),
  .chk_warp_i     (chk_warp_i),
  .chk_dst_i      (chk_dst_i),
  .chk_dst_vld_i  (chk_dst_vld_i),
  .chk_src0_i     (chk_src0_i),
  .chk_src0_vld_i (chk_src0_vld_i),
  .chk_src1_i     (chk_src1_i),
  .chk_src1_vld_i (chk_src1_vld_i),
  .rsv_en_i       (rsv_en_i),
  .rsv_warp_i     (rsv_warp_i),
  .rsv_reg_i      (rsv_reg_i),
  .rel_en_i       (rel_en_i),
  .rel_warp_i     (rel_warp_i),
  .rel_reg_i      (rel_reg_i),
  .clear_o        (clear_o),
  .raw_o          (raw_o),
  .waw_o          (waw_o),
  .rel_err_o      (rel_err_o)
);

// File: tb/test_warp_scoreboard.sv
`timescale 1ns/100ps
module test_warp_scoreboard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] chk_warp = '0;
  logic [5:0] chk_dst = '0, chk_src0 = '0, chk_src1 = '0;
  logic       chk_dst_vld = 1'b0, chk_src0_vld = 1'b0, chk_src1_vld = 1'b0;
  logic       rsv_en = 1'b0, rel_en = 1'b0;
  logic [2:0] rsv_warp = '0, rel_warp = '0;
  logic [5:0] rsv_reg = '0, rel_reg = '0;
  logic       clear_w, raw_w, waw_w, err_w;

  always #2.5 clk = ~clk;

  warp_scoreboard i_warp_scoreboard (
    .clk_i(clk), .rst_ni(rst_n),
    .chk_warp_i(chk_warp), .chk_dst_i(chk_dst), .chk_dst_vld_i(chk_dst_vld),
    .chk_src0_i(chk_src0), .chk_src0_vld_i(chk_src0_vld),
    .chk_src1_i(chk_src1), .chk_src1_vld_i(chk_src1_vld),
    .rsv_en_i(rsv_en), .rsv_warp_i(rsv_warp), .rsv_reg_i(rsv_reg),
    .rel_en_i(rel_en), .rel_warp_i(rel_warp), .rel_reg_i(rel_reg),
    .clear_o(clear_w), .raw_o(raw_w), .waw_o(waw_w), .rel_err_o(err_w)
  );

  typedef struct {
    bit    clr;
    bit    raw;
    bit    waw;
    bit    err;
    string tag;
  } exp_t;

  exp_t  exp_q[$];
  bit    model [8][64];
  bit    err_next = 1'b0;
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  // Driver: applies one cycle of stimulus and predicts the outputs seen before the next edge.
  task automatic apply(input string tag,
                       input int cw, input int cd, input bit dv,
                       input int s0, input bit s0v, input int s1, input bit s1v,
                       input bit re, input int rw, input int rr,
                       input bit le, input int lw, input int lr);
    exp_t e;
    bit   miss;
    @(negedge clk);
    chk_warp = 3'(cw); chk_dst = 6'(cd); chk_dst_vld = dv;
    chk_src0 = 6'(s0); chk_src0_vld = s0v; chk_src1 = 6'(s1); chk_src1_vld = s1v;
    rsv_en = re; rsv_warp = 3'(rw); rsv_reg = 6'(rr);
    rel_en = le; rel_warp = 3'(lw); rel_reg = 6'(lr);
    e.raw = (s0v && model[cw][s0]) || (s1v && model[cw][s1]);
    e.waw = dv && model[cw][cd];
    e.clr = !e.raw && !e.waw;
    e.err = err_next;
    e.tag = tag;
    exp_q.push_back(e);
    miss = le && !model[lw][lr];
    if (le) model[lw][lr] = 1'b0;
    if (re) model[rw][rr] = 1'b1;
    err_next = miss;
  endtask

  task automatic query(input string tag, input int cw, input int cd, input bit dv,
                       input int s0, input bit s0v, input int s1, input bit s1v);
    apply(tag, cw, cd, dv, s0, s0v, s1, s1v, 0, 0, 0, 0, 0, 0);
  endtask

  // Monitor: samples mid-cycle, well after inputs settle and before the next edge.
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_vec++;
        if (clear_w !== e.clr || raw_w !== e.raw || waw_w !== e.waw || err_w !== e.err) begin
          n_bad++;
          $display("FAIL %s: clear/raw/waw/err actual %b%b%b%b expected %b%b%b%b",
                   e.tag, clear_w, raw_w, waw_w, err_w, e.clr, e.raw, e.waw, e.err);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset, every field in use
    query("R1", 0, 0, 1, 1, 1, 2, 1);
    query("R1", 7, 63, 1, 63, 1, 0, 1);

    // R8: reserve w1 r5 while querying it in the same cycle
    apply("R8", 1, 5, 1, 5, 1, 5, 1, 1, 1, 5, 0, 0, 0);
    // R2 / R3: visible next cycle as a source hazard
    query("R3", 1, 9, 1, 5, 1, 0, 0);
    query("R3", 1, 9, 1, 3, 1, 5, 1);
    // R4: destination hazard
    query("R4", 1, 5, 1, 0, 0, 0, 0);
    // R5: other warp, same register number
    query("R5", 2, 5, 1, 5, 1, 5, 1);
    // R10: unused fields naming a pending register
    query("R10", 1, 5, 0, 5, 0, 5, 0);

    // R11: several pending in one warp
    apply("R11", 1, 0, 0, 0, 0, 0, 0, 1, 1, 6, 0, 0, 0);
    apply("R11", 1, 0, 0, 0, 0, 6, 1, 1, 1, 7, 0, 0, 0);
    apply("R6", 1, 7, 1, 0, 0, 0, 0, 0, 0, 0, 1, 1, 5);
    query("R11", 1, 5, 1, 5, 1, 7, 1);
    query("R11", 1, 6, 1, 5, 1, 0, 0);

    // R7: reserve and release of w3 r10 together (also a miss for R9)
    apply("R7", 3, 0, 0, 0, 0, 0, 0, 1, 3, 10, 1, 3, 10);
    query("R7", 3, 10, 1, 0, 0, 0, 0);
    // R7 on an already pending register w1 r6
    apply("R7", 1, 0, 0, 0, 0, 0, 0, 1, 1, 6, 1, 1, 6);
    query("R7", 1, 0, 0, 6, 1, 0, 0);

    // R9: release of w4 r20, never reserved
    apply("R9", 4, 20, 1, 0, 0, 0, 0, 0, 0, 0, 1, 4, 20);
    query("R9", 4, 20, 1, 20, 1, 0, 0);
    query("R9", 1, 6, 1, 7, 1, 0, 0);

    // R6: releasing w3 r10 frees it
    apply("R6", 3, 10, 1, 0, 0, 0, 0, 0, 0, 0, 1, 3, 10);
    query("R6", 3, 10, 1, 10, 1, 10, 1);

    // Mixed traffic over a small register window to force collisions
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      apply("R11", int'(lfsr[0]), int'(lfsr[3:1]), lfsr[4],
            int'(lfsr[7:5]), lfsr[8], int'(lfsr[11:9]), lfsr[12],
            lfsr[13], int'(lfsr[14]), int'(lfsr[2:0]),
            lfsr[15], int'(lfsr[5]), int'(lfsr[10:8]));
    end

    query("R1", 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule